// File: doc/BRIEF.md
# Two-Level Breakpoint Trigger Unit

This block compares processor activity with programmable breakpoint conditions during execution. The processor keeps running while the block watches it. Each cycle it takes the current program counter with a valid strobe, plus an operand address and operand data with their own valid strobe. It checks them against three comparators: a masked program counter match, an inclusive operand address window, and a masked operand data match.

A trigger definition write selects which comparators form level 1 and which form level 2. It also selects one response. With no level-2 comparators enabled, the unit is a one-level trigger. Otherwise a level-1 hit only arms level 2, and the response comes when level 2 fires. The unit keeps a 4-bit breakpoint status and derives a 4-bit trace nibble from it. A status read clears a finished trigger.

When a trigger completes, the unit raises a one-cycle pulse on exactly one output: trace display, halt request, or debug interrupt request. Which one depends on the programmed response.

Top module: `bkpt_trigger_unit`

## Requirements
- R1: The program counter comparator matches when every bit whose `pc_mask_i` bit is 0 equals `pc_ref_i`; a mask bit of 1 excludes that bit. It counts only while `pc_valid_i` is 1.
- R2: The address comparator matches when `addr_lo_i <= op_addr_i <= addr_hi_i` (unsigned, both bounds inclusive) while `op_valid_i` is 1.
- R3: The data comparator matches when every bit whose `data_mask_i` bit is 0 equals `data_ref_i` while `op_valid_i` is 1.
- R4: Each level enable is a 3-bit field with bit 0 = program counter, bit 1 = address, bit 2 = data. A level fires in a cycle only when all of its enabled comparators match in that cycle. A level with no enable bits set never fires.
- R5: Status codes are 0000 idle, 0001 waiting for level 1, 0010 level 1 triggered, 0101 waiting for level 2, and 0110 level 2 triggered. `trace_o` shows 0000, 0010, 0100, 1010 and 1100 for those states. After reset the status is 0000.
- R6: In one-level mode (level-2 enables all zero), a level-1 fire while waiting for level 1 moves the status to 0010 at the next edge.
- R7: In two-level mode, a level-1 fire while waiting for level 1 moves the status to 0101. Level-1 conditions are then ignored. A level-2 fire while in 0101 moves the status to 0110.
- R8: A `csr_rd_i` pulse clears the status to 0000 only in two cases: the status is 0110, or the status is 0010 and level 2 is not enabled. In every other state a read leaves the status unchanged.
- R9: A trigger definition write (`tdef_wr_i`) sets the status to 0000 when both enable fields are zero and to 0001 otherwise. It takes priority over hits and reads in the same cycle.
- R10: On the edge at which the status reaches 0010 or 0110, exactly one response output pulses for one cycle, selected by the stored response code. Code 00 pulses trace, 01 pulses halt, 10 pulses interrupt, and 11 pulses none. At no other time does any response output pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pc_i | input | PC_W | Current program counter |
| pc_valid_i | input | 1 | Program counter valid |
| op_addr_i | input | ADDR_W | Operand address |
| op_data_i | input | DATA_W | Operand data |
| op_valid_i | input | 1 | Operand access valid |
| pc_ref_i | input | PC_W | Program counter reference |
| pc_mask_i | input | PC_W | Program counter mask, 1 = ignore bit |
| addr_lo_i | input | ADDR_W | Address window low bound |
| addr_hi_i | input | ADDR_W | Address window high bound |
| data_ref_i | input | DATA_W | Data reference |
| data_mask_i | input | DATA_W | Data mask, 1 = ignore bit |
| tdef_wr_i | input | 1 | Trigger definition write strobe |
| tdef_l1_en_i | input | 3 | Level-1 comparator enables |
| tdef_l2_en_i | input | 3 | Level-2 comparator enables |
| tdef_resp_i | input | 2 | Response code |
| csr_rd_i | input | 1 | Status read strobe |
| status_o | output | 4 | Breakpoint status |
| trace_o | output | 4 | Trace status nibble |
| trace_pulse_o | output | 1 | Trace display response pulse |
| halt_req_o | output | 1 | Halt request pulse |
| irq_req_o | output | 1 | Debug interrupt request pulse |

## Verification
Directed patterns sit each comparator exactly on its boundaries: the address one below, at, and one above each bound, and a masked bit flipped against an unmasked bit flipped. These separate an off-by-one window or an inverted mask from a correct one. A level enabling two comparators gets a cycle where only one matches, which tells an AND from an OR. Random traffic then runs near the reference values under random enables, responses, reads and rewrites. It exercises one-level versus two-level sequencing, which level-1 hits are ignored once waiting for level 2, and which reads clear and which do not.

// File: rtl/bkpt_pkg.sv
package bkpt_pkg;
  typedef enum logic [3:0] {
    ST_IDLE  = 4'b0000,
    ST_WAIT1 = 4'b0001,
    ST_TRIG1 = 4'b0010,
    ST_WAIT2 = 4'b0101,
    ST_TRIG2 = 4'b0110
  } bkpt_st_e;

  typedef enum logic [1:0] {
    RESP_TRACE = 2'b00,
    RESP_HALT  = 2'b01,
    RESP_IRQ   = 2'b10,
    RESP_NONE  = 2'b11
  } bkpt_resp_e;

  localparam int unsigned N_CMP = 3;
  localparam int unsigned CMP_PC = 0;
  localparam int unsigned CMP_ADDR = 1;
  localparam int unsigned CMP_DATA = 2;

  function automatic logic [3:0] trace_code(input logic [3:0] st);
    case (st)
      ST_WAIT1: trace_code = 4'b0010;
      ST_TRIG1: trace_code = 4'b0100;
      ST_WAIT2: trace_code = 4'b1010;
      ST_TRIG2: trace_code = 4'b1100;
      default:  trace_code = 4'b0000;
    endcase
  endfunction
endpackage

// File: rtl/bkpt_masked_cmp.sv
module bkpt_masked_cmp #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] val_i,
  input  logic [W-1:0] ref_i,
  input  logic [W-1:0] mask_i,
  input  logic         valid_i,
  output logic         match_o
);
  logic [W-1:0] diff;
  assign diff    = (val_i ^ ref_i) & ~mask_i;
  assign match_o = valid_i & ~(|diff);
endmodule

// File: rtl/bkpt_range_cmp.sv
module bkpt_range_cmp #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] val_i,
  input  logic [W-1:0] lo_i,
  input  logic [W-1:0] hi_i,
  input  logic         valid_i,
  output logic         match_o
);
  assign match_o = valid_i & (val_i >= lo_i) & (val_i <= hi_i);
endmodule

// File: rtl/bkpt_seq.sv
module bkpt_seq
  import bkpt_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_CMP-1:0] hit_i,
  input  logic             tdef_wr_i,
  input  logic [N_CMP-1:0] l1_en_i,
  input  logic [N_CMP-1:0] l2_en_i,
  input  logic [1:0]       resp_i,
  input  logic             csr_rd_i,
  output logic [3:0]       status_o,
  output logic             fire_o,
  output logic [1:0]       resp_o
);
  bkpt_st_e         st_q, st_d;
  logic [N_CMP-1:0] l1_en_q, l2_en_q;
  logic [1:0]       resp_q;
  logic             l1_fire, l2_fire, l2_on;

  assign l2_on   = |l2_en_q;
  // every enabled comparator must hit; empty level never fires
  assign l1_fire = (|l1_en_q) & (&(~l1_en_q | hit_i));
  assign l2_fire = l2_on & (&(~l2_en_q | hit_i));

  always_comb begin
    st_d   = st_q;
    fire_o = 1'b0;
    if (tdef_wr_i) begin
      st_d = ((|l1_en_i) | (|l2_en_i)) ? ST_WAIT1 : ST_IDLE;
    end else begin
      case (st_q)
        ST_WAIT1: if (l1_fire) begin
          if (l2_on) st_d = ST_WAIT2;
          else begin
            st_d   = ST_TRIG1;
            fire_o = 1'b1;
          end
        end
        ST_WAIT2: if (l2_fire) begin
          st_d   = ST_TRIG2;
          fire_o = 1'b1;
        end
        ST_TRIG1: if (csr_rd_i && !l2_on) st_d = ST_IDLE;
        ST_TRIG2: if (csr_rd_i) st_d = ST_IDLE;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      l1_en_q <= '0;
      l2_en_q <= '0;
      resp_q  <= RESP_TRACE;
    end else begin
      st_q <= st_d;
      if (tdef_wr_i) begin
        l1_en_q <= l1_en_i;
        l2_en_q <= l2_en_i;
        resp_q  <= resp_i;
      end
    end
  end

  assign status_o = st_q;
  assign resp_o   = resp_q;
endmodule

// File: rtl/bkpt_resp.sv
module bkpt_resp
  import bkpt_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       fire_i,
  input  logic [1:0] resp_i,
  output logic       trace_pulse_o,
  output logic       halt_req_o,
  output logic       irq_req_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      trace_pulse_o <= 1'b0;
      halt_req_o    <= 1'b0;
      irq_req_o     <= 1'b0;
    end else begin
      trace_pulse_o <= fire_i & (resp_i == RESP_TRACE);
      halt_req_o    <= fire_i & (resp_i == RESP_HALT);
      irq_req_o     <= fire_i & (resp_i == RESP_IRQ);
    end
  end
endmodule

// File: rtl/bkpt_trigger_unit.sv
module bkpt_trigger_unit
  import bkpt_pkg::*;
#(
  parameter int unsigned PC_W   = 32,
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [PC_W-1:0]   pc_i,
  input  logic              pc_valid_i,
  input  logic [ADDR_W-1:0] op_addr_i,
  input  logic [DATA_W-1:0] op_data_i,
  input  logic              op_valid_i,
  input  logic [PC_W-1:0]   pc_ref_i,
  input  logic [PC_W-1:0]   pc_mask_i,
  input  logic [ADDR_W-1:0] addr_lo_i,
  input  logic [ADDR_W-1:0] addr_hi_i,
  input  logic [DATA_W-1:0] data_ref_i,
  input  logic [DATA_W-1:0] data_mask_i,
  input  logic              tdef_wr_i,
  input  logic [2:0]        tdef_l1_en_i,
  input  logic [2:0]        tdef_l2_en_i,
  input  logic [1:0]        tdef_resp_i,
  input  logic              csr_rd_i,
  output logic [3:0]        status_o,
  output logic [3:0]        trace_o,
  output logic              trace_pulse_o,
  output logic              halt_req_o,
  output logic              irq_req_o
);
  logic [N_CMP-1:0] hit;
  logic             fire;
  logic [1:0]       resp;

  bkpt_masked_cmp #(.W(PC_W)) u_pc_cmp (
    .val_i(pc_i), .ref_i(pc_ref_i), .mask_i(pc_mask_i),
    .valid_i(pc_valid_i), .match_o(hit[CMP_PC])
  );

  bkpt_range_cmp #(.W(ADDR_W)) u_addr_cmp (
    .val_i(op_addr_i), .lo_i(addr_lo_i), .hi_i(addr_hi_i),
    .valid_i(op_valid_i), .match_o(hit[CMP_ADDR])
  );

  bkpt_masked_cmp #(.W(DATA_W)) u_data_cmp (
    .val_i(op_data_i), .ref_i(data_ref_i), .mask_i(data_mask_i),
    .valid_i(op_valid_i), .match_o(hit[CMP_DATA])
  );

  bkpt_seq u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .hit_i(hit),
    .tdef_wr_i(tdef_wr_i), .l1_en_i(tdef_l1_en_i), .l2_en_i(tdef_l2_en_i),
    .resp_i(tdef_resp_i), .csr_rd_i(csr_rd_i),
    .status_o(status_o), .fire_o(fire), .resp_o(resp)
  );

  bkpt_resp u_resp (
    .clk_i(clk_i), .rst_ni(rst_ni), .fire_i(fire), .resp_i(resp),
    .trace_pulse_o(trace_pulse_o), .halt_req_o(halt_req_o), .irq_req_o(irq_req_o)
  );

  assign trace_o = trace_code(status_o);
endmodule

// File: rtl/bkpt_trigger_unit_chk.sv
module bkpt_trigger_unit_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       tdef_wr_i,
  input logic [2:0] tdef_l1_en_i,
  input logic [2:0] tdef_l2_en_i,
  input logic       csr_rd_i,
  input logic [3:0] status_o,
  input logic       trace_pulse_o,
  input logic       halt_req_o,
  input logic       irq_req_o
);
  a_r5_status_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o inside {4'h0, 4'h1, 4'h2, 4'h5, 4'h6});

  a_r10_one_response: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({trace_pulse_o, halt_req_o, irq_req_o}));

  a_r10_pulse_on_trigger: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trace_pulse_o | halt_req_o | irq_req_o) |->
      (status_o inside {4'h2, 4'h6}) && !$stable(status_o));

  a_r7_l2_from_wait2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o == 4'h6 && !$stable(status_o)) |-> $past(status_o) == 4'h5);

  a_r9_write_arms: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tdef_wr_i |=> status_o == ((|$past(tdef_l1_en_i) || |$past(tdef_l2_en_i)) ? 4'h1 : 4'h0));

  a_r8_read_clears_l2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csr_rd_i && !tdef_wr_i && status_o == 4'h6) |=> status_o == 4'h0);

  a_r8_read_keeps_wait: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csr_rd_i && !tdef_wr_i && status_o == 4'h0) |=> status_o == 4'h0);
endmodule

bind bkpt_trigger_unit bkpt_trigger_unit_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .tdef_wr_i(tdef_wr_i),
  .tdef_l1_en_i(tdef_l1_en_i), .tdef_l2_en_i(tdef_l2_en_i),
  .csr_rd_i(csr_rd_i), .status_o(status_o),
  .trace_pulse_o(trace_pulse_o), .halt_req_o(halt_req_o), .irq_req_o(irq_req_o)
);

// File: tb/bkpt_trigger_unit_tb_top.sv
module bkpt_trigger_unit_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int W = 32;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [W-1:0] pc, op_addr, op_data, pc_ref, pc_mask, addr_lo, addr_hi, data_ref, data_mask;
  logic pc_valid, op_valid, tdef_wr, csr_rd;
  logic [2:0] l1_en, l2_en;
  logic [1:0] resp;
  logic [3:0] status, trace;
  logic tr_p, halt_p, irq_p;

  int total = 0, bad = 0;
  logic [3:0] m_st = 4'h0;
  logic [2:0] m_l1 = '0, m_l2 = '0;
  logic [1:0] m_resp = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bkpt_trigger_unit dut_i (
    .clk_i(clk), .rst_ni(rst_n), .pc_i(pc), .pc_valid_i(pc_valid),
    .op_addr_i(op_addr), .op_data_i(op_data), .op_valid_i(op_valid),
    .pc_ref_i(pc_ref), .pc_mask_i(pc_mask), .addr_lo_i(addr_lo), .addr_hi_i(addr_hi),
    .data_ref_i(data_ref), .data_mask_i(data_mask), .tdef_wr_i(tdef_wr),
    .tdef_l1_en_i(l1_en), .tdef_l2_en_i(l2_en), .tdef_resp_i(resp), .csr_rd_i(csr_rd),
    .status_o(status), .trace_o(trace), .trace_pulse_o(tr_p),
    .halt_req_o(halt_p), .irq_req_o(irq_p)
  );

  function automatic logic [3:0] exp_trace(input logic [3:0] s);
    case (s)
      4'h1: return 4'b0010;
      4'h2: return 4'b0100;
      4'h5: return 4'b1010;
      4'h6: return 4'b1100;
      default: return 4'b0000;
    endcase
  endfunction

  function automatic logic [2:0] hits();
    logic [2:0] h;
    h[0] = pc_valid && (((pc ^ pc_ref) & ~pc_mask) == '0);
    h[1] = op_valid && (op_addr >= addr_lo) && (op_addr <= addr_hi);
    h[2] = op_valid && (((op_data ^ data_ref) & ~data_mask) == '0);
    return h;
  endfunction

  function automatic logic lvl(input logic [2:0] en, input logic [2:0] h);
    return (en != 0) && ((en & h) == en);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle_in();
    pc_valid = 0; op_valid = 0; tdef_wr = 0; csr_rd = 0;
  endtask

  // one clock: model the edge from current inputs, then compare after it
  task automatic step(input string req);
    logic [2:0] h;
    logic [3:0] nst;
    logic fire;
    h = hits(); nst = m_st; fire = 0;
    if (tdef_wr) begin
      nst = (l1_en != 0 || l2_en != 0) ? 4'h1 : 4'h0;
    end else begin
      case (m_st)
        4'h1: if (lvl(m_l1, h)) begin
          if (m_l2 != 0) nst = 4'h5; else begin nst = 4'h2; fire = 1; end
        end
        4'h5: if (lvl(m_l2, h)) begin nst = 4'h6; fire = 1; end
        4'h2: if (csr_rd && m_l2 == 0) nst = 4'h0;
        4'h6: if (csr_rd) nst = 4'h0;
        default: ;
      endcase
    end
    @(posedge clk);
    if (tdef_wr) begin m_l1 = l1_en; m_l2 = l2_en; m_resp = resp; end
    m_st = nst;
    #1;
    check(req, status, m_st);
    check("R5", trace, exp_trace(m_st));
    check("R10", {tr_p, halt_p, irq_p},
          {fire && m_resp == 2'b00, fire && m_resp == 2'b01, fire && m_resp == 2'b10});
    @(negedge clk);
    idle_in();
  endtask

  task automatic define(input logic [2:0] a, input logic [2:0] b, input logic [1:0] r);
    tdef_wr = 1; l1_en = a; l2_en = b; resp = r;
    step("R9");
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    idle_in();
    pc = 0; op_addr = 0; op_data = 0; l1_en = 0; l2_en = 0; resp = 0;
    pc_ref = 32'h0000_1000; pc_mask = 32'h0000_000F;
    addr_lo = 32'h0000_2000; addr_hi = 32'h0000_20FF;
    data_ref = 32'hCAFE_0000; data_mask = 32'h0000_FF00;
    #(CLK_PERIOD * 3);
    @(negedge clk);
    check("R5 reset status", status, 4'h0);
    check("R5 reset trace", trace, 4'h0);
    rst_n = 1;
    @(negedge clk);

    // R1: masked bits ignored, unmasked bit counts
    define(3'b001, 3'b000, 2'b01);
    pc_valid = 1; pc = 32'h0000_1010; step("R1 unmasked bit differs");
    pc_valid = 1; pc = 32'h0000_100A; step("R1 masked bits differ");
    check("R1 halt pulse", halt_p, 1'b1);
    csr_rd = 1; step("R8 read clears one-level");
    // R2: inclusive bounds
    define(3'b010, 3'b000, 2'b10);
    op_valid = 1; op_addr = 32'h0000_1FFF; step("R2 below low");
    op_valid = 1; op_addr = 32'h0000_2100; step("R2 above high");
    op_valid = 1; op_addr = 32'h0000_20FF; step("R2 at high");
    define(3'b010, 3'b000, 2'b10);
    op_valid = 1; op_addr = 32'h0000_2000; step("R2 at low");
    // R3 and R4: AND of pc and data, one matching alone does not fire
    define(3'b101, 3'b000, 2'b00);
    pc_valid = 1; pc = 32'h0000_1000; op_valid = 1; op_data = 32'hCAFE_0001; step("R4 only pc");
    op_valid = 1; op_data = 32'hCAFE_AB00; step("R4 only data");
    pc_valid = 1; op_valid = 1; op_data = 32'hCAFE_1200; step("R3 data masked match with pc");
    csr_rd = 1; step("R8 read clear");
    // R7: two-level, level-1 ignored while waiting for level 2
    define(3'b001, 3'b010, 2'b10);
    pc_valid = 1; step("R7 l1 fires arms l2");
    pc_valid = 1; step("R7 l1 ignored");
    csr_rd = 1; step("R8 read in wait2 no effect");
    op_valid = 1; op_addr = 32'h0000_2010; step("R7 l2 fires");
    csr_rd = 1; step("R8 read clears l2");
    // R9: write with no enables idles, write beats hit
    define(3'b000, 3'b000, 2'b00);
    define(3'b001, 3'b000, 2'b00);
    pc_valid = 1; tdef_wr = 1; l1_en = 3'b001; l2_en = 0; resp = 2'b11; step("R9 write priority");
    pc_valid = 1; step("R6 one-level resp none");

    // random phase
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] r;
      r = $urandom;
      pc_valid = r[0]; op_valid = r[1];
      pc = pc_ref ^ (r[2] ? {28'h0, r[7:4]} : {r[27:24], 4'h0, r[11:8], 20'h0});
      op_addr = addr_lo - 32'd2 + {24'h0, r[15:8]} + (r[3] ? 32'd0 : 32'd3);
      op_data = data_ref ^ (r[16] ? {16'h0, r[23:20], 4'h0, r[27:24]} : {16'h0, r[31:28], 12'h0});
      csr_rd = (r[19:17] == 0);
      tdef_wr = (r[31:28] == 0) && (r[5:4] == 0);
      if (tdef_wr) begin
        r = $urandom;
        l1_en = r[2:0]; l2_en = r[3] ? r[6:4] : 3'b000; resp = r[9:8];
        step("R9");
      end else if (csr_rd) step("R8");
      else if (m_l2 != 0) step("R7");
      else step("R6");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule